// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor with Speculative History Queue

This block predicts whether a conditional branch is taken. Three component predictors each hold tables of 2-bit saturating counters. The first is a bimodal table indexed by branch address. The second is a global-history table indexed by the address XOR the global history. The third is a local-history table indexed by a per-address history pattern. A selector table, also indexed by address, picks which component's counter gives the final answer. The answer comes back in the same cycle as the request, and a new request can be made in every cycle.

Each accepted prediction appends its predicted direction, along with the local-history slot it belongs to, to a short speculative history queue. Lookups use the committed histories extended by the queued bits, so branches issued back to back see each other's predicted outcomes. The queue commits its oldest entry into the committed global history and into that entry's local history only when the queue is full and a new prediction arrives. A flush discards every queued entry. A separate resolve port trains the counters. It carries the branch address, the real outcome, and the two history-derived indices that were reported with the prediction.

Top module: `hybrid_dir_pred`

## Requirements
- R1: After reset, all counters hold 01 (weakly not taken), all histories are zero and the queue is empty. The first prediction is not taken, comes from the bimodal component (code 0), has a global index equal to the address bits, and has a local pattern of zero.
- R2: Each selector entry holds two counters, a choice counter and a history counter. If the choice counter's MSB is 0, the bimodal component is used (code 0). Otherwise the global component (code 2) is used when the history counter's MSB is 1, and the local component (code 1) when it is 0. The direction output is the MSB of the chosen component's counter. Code 3 never appears.
- R3: The global index equals the low GHIST_W address bits XOR the speculative global history. The local pattern equals the speculative local history of slot `addr[LIDX_W-1:0]` and indexes the local counter table.
- R4: An accepted request (valid, no flush) appends its predicted direction to the queue. Speculative histories are the committed history shifted left by each queued bit, oldest first, with the newest bit at the LSB. For local history, only queued entries with a matching slot are applied. A cycle without a request or flush leaves both histories unchanged.
- R5: The queue holds at most SHQ_DEPTH entries. A request that arrives while the queue is full shifts the oldest entry out. That entry's bit is shifted into the committed global history and into its slot's committed local history. No commit happens otherwise.
- R6: A flush empties the queue, and a request in the same cycle is not queued. Later lookups use the committed histories only.
- R7: On resolve, the selection is re-evaluated from the selector entry at that time. Only the chosen component's counter at the given index moves toward the outcome.
- R8: The history counter moves only when the local and global components disagree, upward if global was right and downward otherwise. The choice counter moves only when bimodal disagrees with the history component picked by the history counter, upward if that history component was right and downward otherwise.
- R9: All counters saturate at 00 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Prediction request this cycle |
| req_addr | input | ADDR_W | Branch address bits of the request |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_src | output | 2 | Chosen component: 0 bimodal, 1 local, 2 global |
| pred_gidx | output | GHIST_W | Global table index used, returned on resolve |
| pred_lpat | output | LHIST_W | Local pattern used, returned on resolve |
| flush | input | 1 | Discard all queued speculative history |
| res_valid | input | 1 | Resolve/update this cycle |
| res_addr | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_gidx | input | GHIST_W | Global index reported with the prediction |
| res_lpat | input | LHIST_W | Local pattern reported with the prediction |

## Verification
The bench builds the block with a 4-bit address and global history, 2-bit local slots, 3-bit local histories, a 3-bit selector index and a 4-entry queue. At these sizes every table fits in a few dozen entries. Random resolves therefore reach counter saturation, selector swings and index aliasing quickly. Requests with a shared slot fill and overflow the queue many times, so commits into both the global and the local history are exercised along with flushes at every fill level.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam logic [1:0] SRC_BIM = 2'd0;
  localparam logic [1:0] SRC_LOC = 2'd1;
  localparam logic [1:0] SRC_GLB = 2'd2;
  localparam logic [1:0] CTR_INIT = 2'b01;

  function automatic logic [1:0] sat_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic [1:0] pick_src(input logic [1:0] c_choice, input logic [1:0] c_hist);
    if (!c_choice[1]) return SRC_BIM;
    else if (c_hist[1]) return SRC_GLB;
    else return SRC_LOC;
  endfunction
endpackage

// File: rtl/hp_ctr_table.sv
module hp_ctr_table
  import hp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output logic [1:0]       up_ctr,
  input  logic             up_en,
  input  logic             up_dir
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] ctr_d;

  assign rd_ctr = ctr_q[rd_idx];
  assign up_ctr = ctr_q[up_idx];

  always_comb ctr_d = sat_step(up_ctr, up_dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
    end else if (up_en) begin
      ctr_q[up_idx] <= ctr_d;
    end
  end
endmodule

// File: rtl/hp_shq.sv
module hp_shq #(
  parameter int GHIST_W = 12,
  parameter int LHIST_W = 10,
  parameter int LIDX_W  = 10,
  parameter int DEPTH   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               push_bit,
  input  logic [LIDX_W-1:0]  push_lidx,
  input  logic               flush,
  input  logic [LIDX_W-1:0]  look_lidx,
  output logic [GHIST_W-1:0] spec_ghist,
  output logic [LHIST_W-1:0] spec_lhist,
  output logic [CNT_W-1:0]   fill
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LENT   = 1 << LIDX_W;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DEPTH-1:0]   bit_q, bit_d;
  logic [LIDX_W-1:0]  lid_q [DEPTH];
  logic [LIDX_W-1:0]  lid_d [DEPTH];
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [GHIST_W-1:0] gh_q, gh_d;
  logic [LHIST_W-1:0] lh_q [LENT];
  logic [LHIST_W-1:0] lh_new;
  logic [SLOT_W-1:0]  slot;
  logic               full, commit;

  assign full   = (cnt_q == FULL_CNT);
  assign commit = push && !flush && full;
  assign slot   = cnt_q[SLOT_W-1:0];
  assign fill   = cnt_q;
  assign lh_new = {lh_q[lid_q[0]][LHIST_W-2:0], bit_q[0]};

  // Next state of the queue and committed global history
  always_comb begin
    bit_d = bit_q;
    lid_d = lid_q;
    cnt_d = cnt_q;
    gh_d  = gh_q;
    if (flush) begin
      cnt_d = '0;
    end else if (push) begin
      if (full) begin
        for (int j = 0; j < DEPTH - 1; j++) begin
          bit_d[j] = bit_q[j+1];
          lid_d[j] = lid_q[j+1];
        end
        bit_d[DEPTH-1] = push_bit;
        lid_d[DEPTH-1] = push_lidx;
        gh_d = {gh_q[GHIST_W-2:0], bit_q[0]};
      end else begin
        bit_d[slot] = push_bit;
        lid_d[slot] = push_lidx;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // Committed history extended by the queued speculative bits
  always_comb begin
    spec_ghist = gh_q;
    spec_lhist = lh_q[look_lidx];
    for (int j = 0; j < DEPTH; j++) begin
      if (CNT_W'(j) < cnt_q) begin
        spec_ghist = {spec_ghist[GHIST_W-2:0], bit_q[j]};
        if (lid_q[j] == look_lidx) spec_lhist = {spec_lhist[LHIST_W-2:0], bit_q[j]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gh_q  <= '0;
      for (int i = 0; i < LENT; i++) lh_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      gh_q  <= gh_d;
      if (commit) lh_q[lid_q[0]] <= lh_new;
    end
  end

  // Payload registers: only read while covered by the fill count
  always_ff @(posedge clk) begin
    bit_q <= bit_d;
    lid_q <= lid_d;
  end
endmodule

// File: rtl/hybrid_dir_pred.sv
module hybrid_dir_pred
  import hp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int GHIST_W   = 12,
  parameter int LIDX_W    = 10,
  parameter int LHIST_W   = 10,
  parameter int META_W    = 10,
  parameter int SHQ_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               pred_taken,
  output logic [1:0]         pred_src,
  output logic [GHIST_W-1:0] pred_gidx,
  output logic [LHIST_W-1:0] pred_lpat,
  input  logic               flush,
  input  logic               res_valid,
  input  logic [ADDR_W-1:0]  res_addr,
  input  logic               res_taken,
  input  logic [GHIST_W-1:0] res_gidx,
  input  logic [LHIST_W-1:0] res_lpat
);
  localparam int CNT_W = $clog2(SHQ_DEPTH + 1);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [GHIST_W-1:0] spec_g;
  logic [LHIST_W-1:0] spec_l;
  logic [CNT_W-1:0]   shq_fill;
  logic [1:0]         p_bim, p_glb, p_loc, p_c0, p_c1;
  logic [1:0]         r_bim, r_glb, r_loc, r_c0, r_c1;
  logic [1:0]         r_src;
  logic               r_hp;
  logic               bim_en, glb_en, loc_en, c0_en, c1_en, c0_up, c1_up;
  logic               push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign push = req_valid && !flush;

  hp_shq #(.GHIST_W(GHIST_W), .LHIST_W(LHIST_W), .LIDX_W(LIDX_W), .DEPTH(SHQ_DEPTH)) i_shq (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .push_bit(pred_taken),
    .push_lidx(req_addr[LIDX_W-1:0]), .flush(flush), .look_lidx(req_addr[LIDX_W-1:0]),
    .spec_ghist(spec_g), .spec_lhist(spec_l), .fill(shq_fill));

  assign pred_gidx = req_addr[GHIST_W-1:0] ^ spec_g;
  assign pred_lpat = spec_l;

  hp_ctr_table #(.IDX_W(ADDR_W)) i_bim (
    .clk(clk), .rst_n(rst_sync_n), .rd_idx(req_addr), .rd_ctr(p_bim),
    .up_idx(res_addr), .up_ctr(r_bim), .up_en(bim_en), .up_dir(res_taken));
  hp_ctr_table #(.IDX_W(GHIST_W)) i_glb (
    .clk(clk), .rst_n(rst_sync_n), .rd_idx(pred_gidx), .rd_ctr(p_glb),
    .up_idx(res_gidx), .up_ctr(r_glb), .up_en(glb_en), .up_dir(res_taken));
  hp_ctr_table #(.IDX_W(LHIST_W)) i_loc (
    .clk(clk), .rst_n(rst_sync_n), .rd_idx(pred_lpat), .rd_ctr(p_loc),
    .up_idx(res_lpat), .up_ctr(r_loc), .up_en(loc_en), .up_dir(res_taken));
  hp_ctr_table #(.IDX_W(META_W)) i_choice (
    .clk(clk), .rst_n(rst_sync_n), .rd_idx(req_addr[META_W-1:0]), .rd_ctr(p_c0),
    .up_idx(res_addr[META_W-1:0]), .up_ctr(r_c0), .up_en(c0_en), .up_dir(c0_up));
  hp_ctr_table #(.IDX_W(META_W)) i_histsel (
    .clk(clk), .rst_n(rst_sync_n), .rd_idx(req_addr[META_W-1:0]), .rd_ctr(p_c1),
    .up_idx(res_addr[META_W-1:0]), .up_ctr(r_c1), .up_en(c1_en), .up_dir(c1_up));

  // Prediction path
  always_comb begin
    pred_src = pick_src(p_c0, p_c1);
    unique case (pred_src)
      SRC_LOC: pred_taken = p_loc[1];
      SRC_GLB: pred_taken = p_glb[1];
      default: pred_taken = p_bim[1];
    endcase
  end

  // Resolve path: train the chosen component and the selector
  always_comb begin
    r_src  = pick_src(r_c0, r_c1);
    r_hp   = r_c1[1] ? r_glb[1] : r_loc[1];
    bim_en = res_valid && (r_src == SRC_BIM);
    loc_en = res_valid && (r_src == SRC_LOC);
    glb_en = res_valid && (r_src == SRC_GLB);
    c1_en  = res_valid && (r_loc[1] != r_glb[1]);
    c1_up  = (r_glb[1] == res_taken);
    c0_en  = res_valid && (r_bim[1] != r_hp);
    c0_up  = (r_hp == res_taken);
  end
endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
  parameter int GHIST_W = 12,
  parameter int DEPTH   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               flush,
  input logic [1:0]         pred_src,
  input logic [CNT_W-1:0]   fill,
  input logic [GHIST_W-1:0] spec_ghist
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assert_src_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_src != 2'd3);

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_CNT);

  assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FULL_CNT && req_valid && !flush) |=> fill == FULL_CNT);

  assert_push_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flush && fill < FULL_CNT) |=> fill == CNT_W'($past(fill) + 1'b1));

  assert_idle_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !flush) |=> $stable(spec_ghist));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fill == '0);
endmodule

bind hybrid_dir_pred hp_checker #(.GHIST_W(GHIST_W), .DEPTH(SHQ_DEPTH)) i_hp_checker (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .flush(flush),
  .pred_src(pred_src), .fill(shq_fill), .spec_ghist(spec_g));

// File: tb/test_hybrid_dir_pred.sv
module test_hybrid_dir_pred;
  localparam int AW = 4, GW = 4, LIW = 2, LHW = 3, MW = 3, QD = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, flush, res_valid, res_taken;
  logic [AW-1:0] req_addr, res_addr;
  logic [GW-1:0] res_gidx, pred_gidx;
  logic [LHW-1:0] res_lpat, pred_lpat;
  logic pred_taken;
  logic [1:0] pred_src;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  hybrid_dir_pred #(.ADDR_W(AW), .GHIST_W(GW), .LIDX_W(LIW), .LHIST_W(LHW),
                    .META_W(MW), .SHQ_DEPTH(QD)) i_hybrid_dir_pred (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .pred_taken(pred_taken), .pred_src(pred_src), .pred_gidx(pred_gidx),
    .pred_lpat(pred_lpat), .flush(flush), .res_valid(res_valid), .res_addr(res_addr),
    .res_taken(res_taken), .res_gidx(res_gidx), .res_lpat(res_lpat));

  // Reference model state
  int m_bim[1<<AW], m_glb[1<<GW], m_loc[1<<LHW], m_c0[1<<MW], m_c1[1<<MW];
  logic [LHW-1:0] m_lh[1<<LIW];
  logic [GW-1:0] m_gh;
  logic [QD-1:0] q_bit;
  int q_lid[QD];
  int q_cnt;

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int sel(int c0, int c1);
    if (c0 < 2) return 0;
    return (c1 >= 2) ? 2 : 1;
  endfunction

  function automatic logic [GW-1:0] spec_g();
    logic [GW-1:0] g = m_gh;
    for (int j = 0; j < q_cnt; j++) g = {g[GW-2:0], q_bit[j]};
    return g;
  endfunction

  function automatic logic [LHW-1:0] spec_l(int l);
    logic [LHW-1:0] h = m_lh[l];
    for (int j = 0; j < q_cnt; j++) if (q_lid[j] == l) h = {h[LHW-2:0], q_bit[j]};
    return h;
  endfunction

  task automatic chk(string ph, string rq, string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL [%s] %s %s: actual %0h expected %0h", ph, rq, fld, act, exp);
    end
  endtask

  task automatic reset_model();
    foreach (m_bim[i]) m_bim[i] = 1;
    foreach (m_glb[i]) m_glb[i] = 1;
    foreach (m_loc[i]) m_loc[i] = 1;
    foreach (m_c0[i]) m_c0[i] = 1;
    foreach (m_c1[i]) m_c1[i] = 1;
    foreach (m_lh[i]) m_lh[i] = '0;
    m_gh = '0; q_bit = '0; q_cnt = 0;
    foreach (q_lid[i]) q_lid[i] = 0;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(bit rv, logic [AW-1:0] pc, bit fl, bit rsv, logic [AW-1:0] rpc,
                      bit rt, logic [GW-1:0] rgi, logic [LHW-1:0] rlp, string ph);
    int src, ctr, lid;
    bit tk;
    logic [GW-1:0] gi;
    logic [LHW-1:0] lp;
    int rb, rg, rl, c0, c1, rs, bp, lpp, gp, hp;
    req_valid = rv; req_addr = pc; flush = fl;
    res_valid = rsv; res_addr = rpc; res_taken = rt; res_gidx = rgi; res_lpat = rlp;
    #1;
    lid = int'(pc[LIW-1:0]);
    gi  = pc[GW-1:0] ^ spec_g();
    lp  = spec_l(lid);
    src = sel(m_c0[pc[MW-1:0]], m_c1[pc[MW-1:0]]);
    ctr = (src == 0) ? m_bim[pc] : (src == 1) ? m_loc[lp] : m_glb[gi];
    tk  = (ctr >= 2);
    chk(ph, "R2", "pred_taken", int'(pred_taken), int'(tk));
    chk(ph, "R2", "pred_src", int'(pred_src), src);
    chk(ph, "R3", "pred_gidx", int'(pred_gidx), int'(gi));
    chk(ph, "R4", "pred_lpat", int'(pred_lpat), int'(lp));
    @(posedge clk);
    if (rsv) begin
      rb = m_bim[rpc]; rg = m_glb[rgi]; rl = m_loc[rlp];
      c0 = m_c0[rpc[MW-1:0]]; c1 = m_c1[rpc[MW-1:0]];
      bp = rb >= 2; lpp = rl >= 2; gp = rg >= 2;
      rs = sel(c0, c1);
      if (rs == 0) m_bim[rpc] = sat(rb, rt);
      else if (rs == 1) m_loc[rlp] = sat(rl, rt);
      else m_glb[rgi] = sat(rg, rt);
      hp = (c1 >= 2) ? gp : lpp;
      if (lpp != gp) m_c1[rpc[MW-1:0]] = sat(c1, gp == int'(rt));
      if (bp != hp) m_c0[rpc[MW-1:0]] = sat(c0, hp == int'(rt));
    end
    if (fl) q_cnt = 0;
    else if (rv) begin
      if (q_cnt == QD) begin
        m_gh = {m_gh[GW-2:0], q_bit[0]};
        m_lh[q_lid[0]] = {m_lh[q_lid[0]][LHW-2:0], q_bit[0]};
        for (int j = 0; j < QD - 1; j++) begin q_bit[j] = q_bit[j+1]; q_lid[j] = q_lid[j+1]; end
        q_bit[QD-1] = tk; q_lid[QD-1] = lid;
      end else begin
        q_bit[q_cnt] = tk; q_lid[q_cnt] = lid; q_cnt++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 0; flush = 0; res_valid = 0;
    req_addr = '0; res_addr = '0; res_taken = 0; res_gidx = '0; res_lpat = '0;
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state seen at the ports
    step(0, 4'hA, 0, 0, 4'h0, 0, 4'h0, 3'h0, "R1");
    chk("R1", "R1", "reset taken", int'(pred_taken), 0);

    // R9: bimodal saturation both ways
    repeat (6) step(0, 4'h0, 0, 1, 4'h3, 1, 4'h3, 3'h0, "R9");
    repeat (5) step(0, 4'h0, 0, 1, 4'h4, 0, 4'h4, 3'h0, "R9");
    // R7: only the chosen (bimodal) counter learned
    step(1, 4'h3, 0, 0, 4'h0, 0, 4'h0, 3'h0, "R7");
    step(1, 4'h4, 0, 0, 4'h0, 0, 4'h0, 3'h0, "R7");

    // R8: selector swings once bimodal and history disagree
    repeat (3) step(0, 4'h0, 0, 1, 4'h6, 1, 4'h9, 3'h5, "R8");
    repeat (4) step(0, 4'h0, 0, 1, 4'h6, 0, 4'h9, 3'h5, "R8");
    step(0, 4'h6, 0, 0, 4'h0, 0, 4'h0, 3'h0, "R8");
    step(0, 4'hE, 0, 0, 4'h0, 0, 4'h0, 3'h0, "R8");

    // R4/R5: shared local slot, fill then overflow the queue
    for (int k = 0; k < 10; k++)
      step(1, (k % 3 == 0) ? 4'h3 : 4'h7, 0, 0, 4'h0, 0, 4'h0, 3'h0, (k < QD) ? "R4" : "R5");

    // R6: flush with a same-cycle request, then a lookup
    step(1, 4'h3, 1, 0, 4'h0, 0, 4'h0, 3'h0, "R6");
    step(1, 4'h3, 0, 0, 4'h0, 0, 4'h0, 3'h0, "R6");
    step(0, 4'h3, 0, 0, 4'h0, 0, 4'h0, 3'h0, "R6");

    // Random traffic
    for (int n = 0; n < 4000; n++)
      step(($urandom % 4) != 0, 4'($urandom), ($urandom % 24) == 0, ($urandom % 2) == 1,
           4'($urandom), ($urandom % 3) != 0, 4'($urandom), 3'($urandom), "RND");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule